// File: doc/BRIEF.md
# Bit-Serial Adder with Start-of-Word Flag

This block adds two unsigned words of any length one bit position per clock cycle. It reuses a single full-adder slice on every cycle, so no carry chain across bit positions is needed. The two operand streams arrive least significant bit first on the inputs `a` and `b`. One sum bit leaves on `sum_out` in the same cycle. A one-bit register carries the carry-out of each step into the next step.

The caller raises `first` in the cycle that holds bit 0 of a new operand pair. In that cycle the slice takes a carry-in of zero, whatever the register holds. A new addition can therefore follow the previous one directly, with no reset and no bit counter. The stored carry is visible on `carry_q`. After the last bit of a word has been clocked in with `en` high, `carry_q` holds the carry out of the most significant position. The caller decides how many bits a word has. The block itself has no notion of word length.

Top module: `bit_serial_adder`

## Requirements
- R1: When `rst` is high at a rising clock edge, `carry_q` is 0 after that edge. `rst` takes priority over `en`.
- R2: In every cycle, `sum_out` equals `a` XOR `b` XOR cin, a combinational function of the current inputs. cin is the stored carry `carry_q` when `first` is 0.
- R3: When `first` is 1, cin is 0 for that cycle, even when `carry_q` is 1.
- R4: At a rising edge with `en` high and `rst` low, `carry_q` loads the majority of `a`, `b` and cin.
- R5: At a rising edge with `en` low and `rst` low, `carry_q` keeps its value, whatever `a`, `b` and `first` are.
- R6: Take two W-bit words A and B, presented LSB first over W cycles with `first` high only on bit 0 and `en` high throughout. The bits seen on `sum_out` in those cycles, read LSB first, equal the low W bits of A+B. After the last edge, `carry_q` equals bit W of A+B.
- R7: A new operation may start in the cycle right after the previous one ends, with no reset between them. Its result does not depend on the carry the previous operation left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the carry register |
| en | input | 1 | Step enable; the carry register updates only when high |
| first | input | 1 | High in the cycle that holds bit 0 of a new operand pair |
| a | input | 1 | Serial bit of operand A, LSB first |
| b | input | 1 | Serial bit of operand B, LSB first |
| sum_out | output | 1 | Serial sum bit for the current position |
| carry_q | output | 1 | Stored carry from the previous enabled step |

## Verification
The main function is tried with a fixed table of word pairs and then with random pairs, always back to back. The fixed table holds all zeros, all ones plus one, all ones plus all ones, top bits only, and interleaved complementary patterns. All ones plus one runs a carry through every position and out the top. Complementary patterns give all-ones sums with no carry at all. Zero plus zero right after a carry-out word shows whether `first` really discards the stale carry. Directed single-cycle cases separate the carry-in select from the register: the register is first set to 1, then `first` and `en` are toggled, which shows whether the zero carry-in, the hold, and the reset priority each act on their own.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  // One-bit sum of a full adder, written as a parity.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // Carry out of a full adder: generate, or propagate an incoming carry.
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  // Carry-in chosen for a step: zero on the first bit of a word.
  function automatic logic pick_cin(input logic start, input logic stored);
    return start ? 1'b0 : stored;
  endfunction

endpackage

// File: rtl/sadd_cin_sel.sv
module sadd_cin_sel
  import serial_add_pkg::*;
(
  input  logic first,
  input  logic stored,
  output logic cin
);

  always_comb begin
    cin = pick_cin(first, stored);
  end

endmodule

// File: rtl/sadd_slice.sv
module sadd_slice
  import serial_add_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);

  always_comb begin
    sum  = fa_sum(a, b, cin);
    cout = fa_carry(a, b, cin);
  end

endmodule

// File: rtl/sadd_carry_reg.sv
module sadd_carry_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == 1'b0)); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (q == $past(q))); // R5

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic sum_out,
  output logic carry_q
);

  // Named internal events between the pieces, kept visible for the checks.
  logic cin_w;
  logic cout_w;

  sadd_cin_sel u_sel (
    .first  (first),
    .stored (carry_q),
    .cin    (cin_w)
  );

  sadd_slice u_fa (
    .a    (a),
    .b    (b),
    .cin  (cin_w),
    .sum  (sum_out),
    .cout (cout_w)
  );

  sadd_carry_reg u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (cout_w),
    .q   (carry_q)
  );

  AST_SUM_PARITY: assert property (@(posedge clk) disable iff (rst)
    ($countones({a, b, cin_w, sum_out}) % 2) == 0); // R2

  AST_FIRST_ZERO_CIN: assert property (@(posedge clk) disable iff (rst)
    first |-> (cin_w == 1'b0)); // R3

  AST_STORED_CIN: assert property (@(posedge clk) disable iff (rst)
    !first |-> (cin_w == carry_q)); // R2

  AST_CARRY_MAJORITY: assert property (@(posedge clk) disable iff (rst)
    en |=> (carry_q == ($countones({$past(a), $past(b), $past(cin_w)}) >= 2))); // R4

endmodule

// File: tb/bit_serial_adder_tb.sv
module bit_serial_adder_tb_top;

  localparam int W = 8;
  localparam int NVEC = 8;
  localparam int NRAND = 40;

  // Each entry packs {A, B}.
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    16'h0000, 16'hFF01, 16'h0000, 16'hFFFF,
    16'h8080, 16'h55AA, 16'h3C5A, 16'h7F01
  };

  logic clk = 1'b0;
  logic rst, en, first, a, b;
  logic sum_out, carry_q;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bit_serial_adder dut_i (
    .clk(clk), .rst(rst), .en(en), .first(first), .a(a), .b(b),
    .sum_out(sum_out), .carry_q(carry_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] opa, input logic [W-1:0] opb, input string req);
    logic [W-1:0] got_sum;
    logic [W:0] exp_full;
    exp_full = {1'b0, opa} + {1'b0, opb};
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      first = (i == 0);
      en = 1'b1;
      a = opa[i];
      b = opb[i];
      #1 got_sum[i] = sum_out;
    end
    @(negedge clk);
    en = 1'b0;
    first = 1'b0;
    a = 1'b0;
    b = 1'b0;
    check({req, " sum"}, 32'(got_sum), 32'(exp_full[W-1:0]));
    check({req, " carry"}, 32'(carry_q), 32'(exp_full[W]));
  endtask

  // One directed step: drive, check sum before the edge, check carry after it.
  task automatic step(input logic f, input logic e, input logic x, input logic y,
                      input logic exp_sum, input logic exp_c, input string req);
    @(negedge clk);
    first = f; en = e; a = x; b = y;
    #1 check({req, " sum"}, 32'(sum_out), 32'(exp_sum));
    @(posedge clk);
    #1 check({req, " carry"}, 32'(carry_q), 32'(exp_c));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; first = 1'b0; a = 1'b0; b = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset state", 32'(carry_q), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk, back to back: R6 and R7 (0000 follows FF01 carry-out).
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][2*W-1:W], VEC[v][W-1:0], "R6/R7 table");
    end
    for (int r = 0; r < NRAND; r++) begin
      run_op(W'($urandom), W'($urandom), "R6 random");
    end

    // Carry-in select and register directed cases.
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 generate");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 stored carry into sum, R4 kill");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 set again");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 first forces cin 0");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 set");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4 propagate");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 hold one");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 hold with first, R3 sum");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 clear");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 hold zero");

    // Reset priority over enable.
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 set before reset");
    @(negedge clk);
    rst = 1'b1; en = 1'b1; first = 1'b0; a = 1'b1; b = 1'b1;
    @(posedge clk);
    #1 check("R1 reset beats enable", 32'(carry_q), 32'h0);
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    run_op(8'hFF, 8'h01, "R6 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule